// File: doc/BRIEF.md
# Clock Output Gating and Power-Down Controller

This block decides, cycle by cycle, whether each of a small set of clock outputs is driving its clock, floating, or held low, and whether the oscillator and the PLLs are running. It takes one multifunction control pin and one configuration-select pin, both asynchronous. It also takes two stored configuration sets. Each set holds the control pin's role, the disabled-output style and a mask of outputs in use. The role can be a plain clock output, a master output enable, or a power-down input.

The two pins pass through two-flop synchronisers. A small state machine then tracks four activities: normal running, master-disabled, powered-down, and switching configuration. Each wake-up from a disabled state is held back by a programmable cycle count. This stands in for the analog settling time that follows release. A power-down request beats everything else. A configuration switch silences the outputs, loads the newly selected set, and waits out its own delay before any output is driven again.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: After reset the active set is 1, the oscillator and PLL enables are 1, and every output in the set-1 mask is driving (outEn bit 1, outForceLow bit 0).
- R2: Each pin level passes through two flops. A level applied before rising edge A first changes the outputs just after the third rising edge, counting A.
- R3: With role code 2'b00 or 2'b11 the control pin is a clock output. Its level is ignored, and output CTRL_IDX follows the mask like any other output.
- R4: With role code 2'b01, a low control level disables all outputs while oscRun and pllRun stay 1.
- R5: With role code 2'b10, a low control level drops oscRun and pllRun to 0 and disables all outputs.
- R6: When outputs are disabled, lowWhenOff 0 gives outEn 0 and outForceLow 0 (high-impedance). lowWhenOff 1 gives outEn and outForceLow both equal to the mask (driven low). With role 2'b01 or 2'b10, output CTRL_IDX is never enabled.
- R7: After the master-enable level returns high, outputs stay disabled for oeWakeCycles+1 cycles. A new low level during that wait returns the block to the disabled state.
- R8: After power-down is released, oscRun and pllRun return at once, and outputs stay disabled for pdWakeCycles+1 cycles.
- R9: When the select level differs from the active set, the new set is loaded and all outputs are disabled with the oscillator running. They are re-enabled swWakeCycles+1 cycles later, or go to the master-disabled state if the new set asks for it. A further select change restarts the wait.
- R10: A power-down request overrides the master-disabled state, a master-enable wake-up and a configuration switch in progress.
- R11: An output whose mask bit is 0 never has outEn or outForceLow set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctlPinAsync | input | 1 | Multifunction control pin level, asynchronous |
| selPinAsync | input | 1 | Configuration select level, asynchronous (1 = set 1) |
| roleSet0 | input | 2 | Set 0 role: 00/11 clock output, 01 master enable, 10 power-down |
| roleSet1 | input | 2 | Set 1 role, same coding |
| lowWhenOff0 | input | 1 | Set 0 disabled style: 0 high-impedance, 1 driven low |
| lowWhenOff1 | input | 1 | Set 1 disabled style |
| usedSet0 | input | N_OUT | Set 0 mask of outputs in use |
| usedSet1 | input | N_OUT | Set 1 mask of outputs in use |
| oeWakeCycles | input | TMR_W | Master-enable re-enable delay in cycles |
| pdWakeCycles | input | TMR_W | Power-down release delay in cycles |
| swWakeCycles | input | TMR_W | Configuration switch delay in cycles |
| outEn | output | N_OUT | Per-output driver enable (0 = high-impedance) |
| outForceLow | output | N_OUT | Per-output force-low while driven |
| oscRun | output | 1 | Oscillator run enable |
| pllRun | output | 1 | PLL run enable |
| activeSet | output | 1 | Currently loaded configuration set |

## Verification
The assertions hold on every cycle for the invariants that need no history. No output carries a clock while the oscillator is stopped, in the cycle it restarts, or in the cycle the active set changes. Force-low never appears without a driver enable. Unused outputs and a control pin used as an input stay quiet. Only the bench scenarios can show the exact wake-up counts, the three-edge synchroniser latency, the priority of power-down over a switch in progress, and the restart of a wait on a repeated request. They do this by comparing every cycle against a reference model under directed and random pin activity.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_OEOFF,
    ST_PDOWN,
    ST_PDWAKE,
    ST_OEWAKE,
    ST_SWITCH
  } ctrlState_e;

  typedef enum logic [1:0] {
    ROLE_CLK  = 2'b00,
    ROLE_OE   = 2'b01,
    ROLE_PD   = 2'b10,
    ROLE_CLK2 = 2'b11
  } pinRole_e;

  typedef enum logic [1:0] {
    DLY_OE = 2'd0,
    DLY_PD = 2'd1,
    DLY_SW = 2'd2
  } delaySel_e;

  typedef struct packed {
    logic      loadSet;
    logic      loadTimer;
    delaySel_e delaySel;
    logic      decTimer;
    logic      outputsOn;
    logic      oscOn;
  } ctrlStrobe_t;

endpackage

// File: rtl/cg_pin_sync.sv
module cg_pin_sync #(
  parameter int WIDTH     = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  // one two-flop chain per pin; reset to the pulled-up level
  for (genvar i = 0; i < WIDTH; i++) begin : g_chain
    logic stage1, stage2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1 <= RESET_VAL;
        stage2 <= RESET_VAL;
      end else begin
        stage1 <= asyncIn[i];
        stage2 <= stage1;
      end
    end
    assign syncOut[i] = stage2;
  end
endmodule

// File: rtl/cg_control.sv
module cg_control
  import clkgate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctlLvl,
  input  logic        selLvl,
  input  pinRole_e    roleNow,
  input  logic        activeSet,
  input  logic        timerZero,
  output ctrlStrobe_t strobe
);
  ctrlState_e state, nextState;

  logic pdReq, oeOff, selDiff;
  assign pdReq   = (roleNow == ROLE_PD) && !ctlLvl;
  assign oeOff   = (roleNow == ROLE_OE) && !ctlLvl;
  assign selDiff = (selLvl != activeSet);

  always_comb begin
    nextState        = state;
    strobe           = '0;
    strobe.delaySel  = DLY_OE;
    strobe.outputsOn = (state == ST_RUN);
    strobe.oscOn     = (state != ST_PDOWN);
    unique case (state)
      ST_RUN: begin
        if (pdReq) nextState = ST_PDOWN;
        else if (selDiff) begin
          nextState        = ST_SWITCH;
          strobe.loadSet   = 1'b1;
          strobe.loadTimer = 1'b1;
          strobe.delaySel  = DLY_SW;
        end else if (oeOff) nextState = ST_OEOFF;
      end
      ST_OEOFF: begin
        if (pdReq) nextState = ST_PDOWN;
        else if (selDiff) begin
          nextState        = ST_SWITCH;
          strobe.loadSet   = 1'b1;
          strobe.loadTimer = 1'b1;
          strobe.delaySel  = DLY_SW;
        end else if (!oeOff) begin
          nextState        = ST_OEWAKE;
          strobe.loadTimer = 1'b1;
          strobe.delaySel  = DLY_OE;
        end
      end
      ST_OEWAKE: begin
        if (pdReq) nextState = ST_PDOWN;
        else if (selDiff) begin
          nextState        = ST_SWITCH;
          strobe.loadSet   = 1'b1;
          strobe.loadTimer = 1'b1;
          strobe.delaySel  = DLY_SW;
        end else if (oeOff) nextState = ST_OEOFF;
        else if (timerZero) nextState = ST_RUN;
        else strobe.decTimer = 1'b1;
      end
      ST_PDOWN: begin
        if (!pdReq) begin
          nextState        = ST_PDWAKE;
          strobe.loadTimer = 1'b1;
          strobe.delaySel  = DLY_PD;
        end
      end
      ST_PDWAKE: begin
        if (pdReq) nextState = ST_PDOWN;
        else if (timerZero) begin
          if (selDiff) begin
            nextState        = ST_SWITCH;
            strobe.loadSet   = 1'b1;
            strobe.loadTimer = 1'b1;
            strobe.delaySel  = DLY_SW;
          end else nextState = ST_RUN;
        end else strobe.decTimer = 1'b1;
      end
      ST_SWITCH: begin
        if (pdReq) nextState = ST_PDOWN;
        else if (selDiff) begin
          strobe.loadSet   = 1'b1;
          strobe.loadTimer = 1'b1;
          strobe.delaySel  = DLY_SW;
        end else if (timerZero) nextState = oeOff ? ST_OEOFF : ST_RUN;
        else strobe.decTimer = 1'b1;
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nextState;
  end
endmodule

// File: rtl/cg_datapath.sv
module cg_datapath
  import clkgate_pkg::*;
#(
  parameter int N_OUT    = 5,
  parameter int TMR_W    = 20,
  parameter int CTRL_IDX = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  logic             selLvl,
  input  logic [1:0]       roleSet0,
  input  logic [1:0]       roleSet1,
  input  logic             lowWhenOff0,
  input  logic             lowWhenOff1,
  input  logic [N_OUT-1:0] usedSet0,
  input  logic [N_OUT-1:0] usedSet1,
  input  logic [TMR_W-1:0] oeWakeCycles,
  input  logic [TMR_W-1:0] pdWakeCycles,
  input  logic [TMR_W-1:0] swWakeCycles,
  output pinRole_e         roleNow,
  output logic             timerZero,
  output logic             activeSet,
  output logic [N_OUT-1:0] outEn,
  output logic [N_OUT-1:0] outForceLow,
  output logic             oscRun,
  output logic             pllRun
);
  localparam logic [TMR_W-1:0] TMR_ONE = TMR_W'(1);

  logic [TMR_W-1:0] waitCnt, loadVal;
  logic             lowNow, pinIsInput;
  logic [N_OUT-1:0] usedNow, usedEff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              activeSet <= 1'b1;
    else if (strobe.loadSet) activeSet <= selLvl;
  end

  always_comb begin
    unique case (strobe.delaySel)
      DLY_PD:  loadVal = pdWakeCycles;
      DLY_SW:  loadVal = swWakeCycles;
      default: loadVal = oeWakeCycles;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                waitCnt <= '0;
    else if (strobe.loadTimer) waitCnt <= loadVal;
    else if (strobe.decTimer)  waitCnt <= waitCnt - TMR_ONE;
  end
  assign timerZero = (waitCnt == '0);

  assign roleNow    = pinRole_e'(activeSet ? roleSet1 : roleSet0);
  assign lowNow     = activeSet ? lowWhenOff1 : lowWhenOff0;
  assign usedNow    = activeSet ? usedSet1 : usedSet0;
  assign pinIsInput = (roleNow == ROLE_OE) || (roleNow == ROLE_PD);

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    if (i == CTRL_IDX) begin : g_pin
      assign usedEff[i] = usedNow[i] && !pinIsInput;
    end else begin : g_plain
      assign usedEff[i] = usedNow[i];
    end
    assign outEn[i]       = usedEff[i] && (strobe.outputsOn || lowNow);
    assign outForceLow[i] = usedEff[i] && !strobe.outputsOn && lowNow;
  end

  assign oscRun = strobe.oscOn;
  assign pllRun = strobe.oscOn;
endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl
  import clkgate_pkg::*;
#(
  parameter int N_OUT    = 5,
  parameter int TMR_W    = 20,
  parameter int CTRL_IDX = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctlPinAsync,
  input  logic             selPinAsync,
  input  logic [1:0]       roleSet0,
  input  logic [1:0]       roleSet1,
  input  logic             lowWhenOff0,
  input  logic             lowWhenOff1,
  input  logic [N_OUT-1:0] usedSet0,
  input  logic [N_OUT-1:0] usedSet1,
  input  logic [TMR_W-1:0] oeWakeCycles,
  input  logic [TMR_W-1:0] pdWakeCycles,
  input  logic [TMR_W-1:0] swWakeCycles,
  output logic [N_OUT-1:0] outEn,
  output logic [N_OUT-1:0] outForceLow,
  output logic             oscRun,
  output logic             pllRun,
  output logic             activeSet
);
  localparam int N_PINS = 2;

  logic [N_PINS-1:0] pinSync;
  ctrlStrobe_t       strobe;
  pinRole_e          roleNow;
  logic              timerZero;

  cg_pin_sync #(.WIDTH(N_PINS), .RESET_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn ({selPinAsync, ctlPinAsync}),
    .syncOut (pinSync)
  );

  cg_control u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctlLvl    (pinSync[0]),
    .selLvl    (pinSync[1]),
    .roleNow   (roleNow),
    .activeSet (activeSet),
    .timerZero (timerZero),
    .strobe    (strobe)
  );

  cg_datapath #(.N_OUT(N_OUT), .TMR_W(TMR_W), .CTRL_IDX(CTRL_IDX)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .selLvl       (pinSync[1]),
    .roleSet0     (roleSet0),
    .roleSet1     (roleSet1),
    .lowWhenOff0  (lowWhenOff0),
    .lowWhenOff1  (lowWhenOff1),
    .usedSet0     (usedSet0),
    .usedSet1     (usedSet1),
    .oeWakeCycles (oeWakeCycles),
    .pdWakeCycles (pdWakeCycles),
    .swWakeCycles (swWakeCycles),
    .roleNow      (roleNow),
    .timerZero    (timerZero),
    .activeSet    (activeSet),
    .outEn        (outEn),
    .outForceLow  (outForceLow),
    .oscRun       (oscRun),
    .pllRun       (pllRun)
  );
endmodule

// File: rtl/clkout_gate_ctrl_chk.sv
module clkout_gate_ctrl_chk #(
  parameter int N_OUT    = 5,
  parameter int TMR_W    = 20,
  parameter int CTRL_IDX = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctlPinAsync,
  input logic             selPinAsync,
  input logic [1:0]       roleSet0,
  input logic [1:0]       roleSet1,
  input logic             lowWhenOff0,
  input logic             lowWhenOff1,
  input logic [N_OUT-1:0] usedSet0,
  input logic [N_OUT-1:0] usedSet1,
  input logic [TMR_W-1:0] oeWakeCycles,
  input logic [TMR_W-1:0] pdWakeCycles,
  input logic [TMR_W-1:0] swWakeCycles,
  input logic [N_OUT-1:0] outEn,
  input logic [N_OUT-1:0] outForceLow,
  input logic             oscRun,
  input logic             pllRun,
  input logic             activeSet
);
  logic [N_OUT-1:0] clkDriven, maskNow;
  logic [1:0]       roleNowChk;
  assign clkDriven  = outEn & ~outForceLow;
  assign maskNow    = activeSet ? usedSet1 : usedSet0;
  assign roleNowChk = activeSet ? roleSet1 : roleSet0;

  // R5: nothing carries a clock while the oscillator is stopped
  a_r5_no_clock_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !oscRun |-> (clkDriven == '0));

  // R8: oscillator restart cycle still has outputs held off
  a_r8_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oscRun) |-> (clkDriven == '0));

  // R6: force-low only with a driver enabled
  a_r6_low_needs_driver: assert property (@(posedge clk) disable iff (!rst_n)
    (outForceLow & ~outEn) == '0);

  // R6: control pin used as an input is never driven
  a_r6_pin_is_input: assert property (@(posedge clk) disable iff (!rst_n)
    (roleNowChk == 2'b01 || roleNowChk == 2'b10) |-> !outEn[CTRL_IDX]);

  // R11: unused outputs stay quiet
  a_r11_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((outEn | outForceLow) & ~maskNow) == '0);

  // R9: loading a new set silences the clocks in that cycle
  a_r9_switch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (activeSet != $past(activeSet)) |-> (clkDriven == '0));
endmodule

bind clkout_gate_ctrl clkout_gate_ctrl_chk #(
  .N_OUT(N_OUT), .TMR_W(TMR_W), .CTRL_IDX(CTRL_IDX)
) u_chk (.*);

// File: tb/clkout_gate_ctrl_tb.sv
module clkout_gate_ctrl_tb;
  localparam int N  = 5;
  localparam int TW = 20;
  localparam int CI = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctlPin = 1'b1, selPin = 1'b1;
  logic [1:0] r0 = 2'b00, r1 = 2'b00;
  logic lo0 = 1'b0, lo1 = 1'b0;
  logic [N-1:0] u0 = '1, u1 = '1;
  logic [TW-1:0] dOe = 20'd3, dPd = 20'd6, dSw = 20'd4;
  logic [N-1:0] outEn, outForceLow;
  logic oscRun, pllRun, activeSet;

  int checks = 0, failures = 0, cycles = 0;
  string curReq = "R1";
  bit finished = 0;

  always #4 clk = ~clk;

  clkout_gate_ctrl #(.N_OUT(N), .TMR_W(TW), .CTRL_IDX(CI)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctlPinAsync(ctlPin), .selPinAsync(selPin),
    .roleSet0(r0), .roleSet1(r1), .lowWhenOff0(lo0), .lowWhenOff1(lo1),
    .usedSet0(u0), .usedSet1(u1), .oeWakeCycles(dOe), .pdWakeCycles(dPd),
    .swWakeCycles(dSw), .outEn(outEn), .outForceLow(outForceLow),
    .oscRun(oscRun), .pllRun(pllRun), .activeSet(activeSet));

  // reference model: 0 run, 1 master off, 2 powered down, 3 pd wake, 4 oe wake, 5 switching
  logic m1, m2, q1, q2, mSet;
  int mMode, mCnt;

  function automatic logic [1:0] roleOf(input logic s);
    return s ? r1 : r0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= 1; m2 <= 1; q1 <= 1; q2 <= 1; mMode <= 0; mCnt <= 0; mSet <= 1;
    end else begin
      automatic int nm = mMode;
      automatic int nc = mCnt;
      automatic logic ns = mSet;
      automatic logic pd = (roleOf(mSet) == 2'b10) && !m2;
      automatic logic oe = (roleOf(mSet) == 2'b01) && !m2;
      automatic logic sd = (q2 != mSet);
      m1 <= ctlPin; m2 <= m1; q1 <= selPin; q2 <= q1;
      if (mMode == 2) begin
        if (!pd) begin nm = 3; nc = dPd; end
      end else if (pd) nm = 2;
      else if (mMode == 3) begin
        if (mCnt == 0) begin
          if (sd) begin nm = 5; ns = q2; nc = dSw; end else nm = 0;
        end else nc = mCnt - 1;
      end else if (sd) begin
        nm = 5; ns = q2; nc = dSw;
      end else if (mMode == 0) begin
        if (oe) nm = 1;
      end else if (mMode == 1) begin
        if (!oe) begin nm = 4; nc = dOe; end
      end else if (mMode == 4) begin
        if (oe) nm = 1; else if (mCnt == 0) nm = 0; else nc = mCnt - 1;
      end else if (mMode == 5) begin
        if (mCnt == 0) nm = oe ? 1 : 0; else nc = mCnt - 1;
      end
      mMode <= nm; mCnt <= nc; mSet <= ns;
    end
  end

  function automatic logic [N-1:0] effMask();
    logic [N-1:0] m = mSet ? u1 : u0;
    logic [1:0] r = roleOf(mSet);
    if (r == 2'b01 || r == 2'b10) m[CI] = 1'b0;
    return m;
  endfunction

  task automatic checkVal(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareModel();
    logic [N-1:0] m = effMask();
    logic lo = mSet ? lo1 : lo0;
    logic on = (mMode == 0);
    checkVal(curReq, "outEn", 32'(outEn), 32'(on ? m : (lo ? m : '0)));
    checkVal(curReq, "outForceLow", 32'(outForceLow), 32'((!on && lo) ? m : '0));
    checkVal(curReq, "oscRun", 32'(oscRun), 32'(mMode != 2));
    checkVal(curReq, "pllRun", 32'(pllRun), 32'(mMode != 2));
    checkVal(curReq, "activeSet", 32'(activeSet), 32'(mSet));
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareModel();
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    checkVal("R1", "outEn", 32'(outEn), 32'h1f);
    checkVal("R1", "oscRun", 32'(oscRun), 1);
    checkVal("R1", "activeSet", 32'(activeSet), 1);

    // R3: pin is a clock output, its level is ignored
    curReq = "R3";
    ctlPin = 0; cyc(8);
    checkVal("R3", "outEn", 32'(outEn), 32'h1f);
    ctlPin = 1; cyc(4);

    // R2: three-edge latency, master-enable role
    curReq = "R2";
    r0 = 2'b01; r1 = 2'b01; cyc(2);
    ctlPin = 0;
    cyc(2);
    checkVal("R2", "outEn still on", 32'(outEn), 32'h1b);
    cyc(1);
    checkVal("R2", "outEn off", 32'(outEn), 32'h00);
    // R4: oscillator keeps running
    curReq = "R4";
    cyc(5);
    checkVal("R4", "oscRun", 32'(oscRun), 1);
    // R7: wake wait, interrupted then completed
    curReq = "R7";
    ctlPin = 1; cyc(4);
    ctlPin = 0; cyc(6);
    ctlPin = 1; cyc(12);
    checkVal("R7", "outEn back", 32'(outEn), 32'h1b);

    // R6: driven-low disabled style, both roles
    curReq = "R6";
    lo1 = 1; ctlPin = 0; cyc(6);
    checkVal("R6", "forceLow", 32'(outForceLow), 32'h1b);
    ctlPin = 1; cyc(8);
    r1 = 2'b10; ctlPin = 0; cyc(6);
    // R5: power-down stops oscillator
    curReq = "R5";
    checkVal("R5", "oscRun", 32'(oscRun), 0);
    lo1 = 0; cyc(3);
    // R8: release
    curReq = "R8";
    ctlPin = 1; cyc(4);
    checkVal("R8", "oscRun back", 32'(oscRun), 1);
    cyc(10);

    // R9: configuration switch, restart by second change
    curReq = "R9";
    r0 = 2'b00; u0 = 5'h0f; selPin = 0; cyc(5);
    checkVal("R9", "activeSet", 32'(activeSet), 0);
    selPin = 1; cyc(4); selPin = 0; cyc(12);
    checkVal("R9", "outEn", 32'(outEn), 32'h0f);

    // R10: power-down during a switch and during master-off
    curReq = "R10";
    r0 = 2'b10; r1 = 2'b10; dSw = 20'd10;
    selPin = 1; cyc(5); ctlPin = 0; cyc(6);
    checkVal("R10", "oscRun", 32'(oscRun), 0);
    ctlPin = 1; cyc(25);
    r0 = 2'b01; r1 = 2'b01; ctlPin = 0; cyc(5);
    r1 = 2'b10; cyc(5);
    checkVal("R10", "oscRun", 32'(oscRun), 0);
    ctlPin = 1; cyc(20);

    // R11: random masks, roles and pins
    curReq = "R11";
    for (int blk = 0; blk < 30; blk++) begin
      r0 = 2'($urandom); r1 = 2'($urandom);
      lo0 = 1'($urandom); lo1 = 1'($urandom);
      u0 = N'($urandom); u1 = N'($urandom);
      dOe = TW'($urandom % 8); dPd = TW'($urandom % 12); dSw = TW'($urandom % 10);
      for (int k = 0; k < 150; k++) begin
        if (($urandom % 10) == 0) ctlPin = ~ctlPin;
        if (($urandom % 25) == 0) selPin = ~selPin;
        cyc(1);
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule